// File: doc/BRIEF.md
# Patterned Byte-Count DMA Channel

This block is one general-purpose DMA channel. It copies a programmed number of bytes between a 24-bit memory space (the A bus) and a 256-entry register page (the B bus). Software programs a control byte, a B-page base, a 24-bit address made of a 16-bit offset and a bank byte, and a 16-bit byte count. It then pulses `start`. Each byte is moved in two phases: a read on the source bus, then a write on the destination bus. Each phase holds its request until the addressed bus answers with `ready`.

The B-page address is not fixed. It follows a short offset pattern that the 3-bit mode field selects, and the pattern repeats for as long as bytes remain. The byte count can stop the pattern part way through. The A-bus offset can stay fixed, count up or count down. The bank byte never moves. A count of zero means a full 65536-byte transfer.

The channel registers are not cleared by reset. They come up holding all ones and keep their contents across a reset.

Top module: `dma_pattern_chan`

## Requirements
- R1: The mode field (control bits 2:0) sets the repeating B offset sequence: 000 gives 0; 001 gives 0,1; 010 and 110 give 0,0; 011 and 111 give 0,0,1,1; 100 gives 0,1,2,3; 101 gives 0,1,0,1. The sequence restarts at its first entry on every `start`.
- R2: Exactly the programmed number of bytes is moved, even when this stops the sequence part way. A count of 5 in mode 100 gives offsets 0,1,2,3,0. A count of 1 gives one access.
- R3: A programmed count of 0x0000 moves 65536 bytes.
- R4: The count register (register addresses 5 low and 6 high) drops by one for each byte written and reads 0 after completion.
- R5: Control bit 3 set keeps the A offset unchanged. When it is clear, the offset (register addresses 2 low and 3 high) goes up by one after each byte if control bit 4 is 0, and down by one if bit 4 is 1, wrapping within 16 bits. The bank byte (register address 4) never changes.
- R6: The B address is the base register (register address 1) plus the sequence offset, modulo 256.
- R7: Control bit 7 clear reads from the A bus and writes to the B bus. Bit 7 set reads from the B bus and writes to the A bus. The data written is the byte just read.
- R8: All registers (register addresses 0 to 6) read 0xFF at power-up. Asserting `rst` leaves their contents unchanged.
- R9: Each byte has one read phase on the source bus and then one write phase on the destination bus. At most one bus is requested at a time, and a phase holds its address and request while `ready` is low.
- R10: `done` is high for exactly one clock, in the cycle after the last write completes, and `busy` is low in that same cycle.
- R11: While `busy` is high, register writes and `start` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the transfer engine only |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select for write and readback |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Readback of the selected register |
| start | input | 1 | Launch a transfer |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-clock completion pulse |
| a_req | output | 1 | A-bus access request |
| a_we | output | 1 | A-bus write (0 = read) |
| a_addr | output | 24 | A-bus address {bank, offset} |
| a_wdata | output | 8 | A-bus write data |
| a_rdata | input | 8 | A-bus read data |
| a_ready | input | 1 | A-bus access completes this cycle |
| b_req | output | 1 | B-bus access request |
| b_we | output | 1 | B-bus write (0 = read) |
| b_addr | output | 8 | B-page address |
| b_wdata | output | 8 | B-bus write data |
| b_rdata | input | 8 | B-bus read data |
| b_ready | input | 1 | B-bus access completes this cycle |

## Verification
The case that is hardest to reach is a count of zero. It needs 65536 bytes to pass through the ports before its length and its final address can be seen. The bench holds both ready inputs high for that one run, so it fits in about 131k cycles, and it checks every byte as it goes instead of storing them. A few cut-off cases are driven directly: a count of 5 against the four-entry sequence, a count of 1, a base of 0xFF, and offsets that wrap in each direction. Random runs with random ready stalls cover the other combinations of mode and control bits.

// File: rtl/dma_pkg.sv
package dma_pkg;
    localparam int DATA_W = 8;
    localparam int OFS_W  = 16;
    localparam int BANK_W = 8;
    localparam int CNT_W  = 16;
    localparam int ABUS_W = OFS_W + BANK_W;
    localparam int PAT_W  = 2;
    localparam int RA_W   = 3;
    localparam int MODE_W = 3;

    localparam int CTL_DIR = 7;
    localparam int CTL_DEC = 4;
    localparam int CTL_FIX = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2
    } eng_state_t;

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] bbase;
        logic [OFS_W-1:0]  ofs;
        logic [BANK_W-1:0] bank;
        logic [CNT_W-1:0]  cnt;
    } chan_regs_t;

    typedef struct packed {
        eng_state_t        st;
        logic [PAT_W-1:0]  idx;
        logic [DATA_W-1:0] data;
        logic              done;
    } eng_t;
endpackage

// File: rtl/dma_pattern_gen.sv
module dma_pattern_gen
    import dma_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  logic [PAT_W-1:0]  idx,
    output logic [PAT_W-1:0]  off
);
    always_comb begin
        case (mode)
            3'b001, 3'b101: off = {1'b0, idx[0]};
            3'b011, 3'b111: off = {1'b0, idx[1]};
            3'b100:         off = idx;
            default:        off = '0;
        endcase
    end
endmodule

// File: rtl/dma_addr_step.sv
module dma_addr_step
    import dma_pkg::*;
(
    input  logic [OFS_W-1:0] ofs,
    input  logic             fixed,
    input  logic             down,
    output logic [OFS_W-1:0] ofs_next
);
    always_comb begin
        if (fixed)
            ofs_next = ofs;
        else if (down)
            ofs_next = ofs - 1'b1;
        else
            ofs_next = ofs + 1'b1;
    end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_we,
    input  logic [RA_W-1:0]   cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              adv,
    input  logic [OFS_W-1:0]  ofs_next,
    output chan_regs_t        regs
);
    chan_regs_t regs_d;
    chan_regs_t regs_q = '1;

    always_comb begin
        regs_d = regs_q;
        if (cpu_we) begin
            case (cpu_addr)
                3'd0: regs_d.ctrl       = cpu_wdata;
                3'd1: regs_d.bbase      = cpu_wdata;
                3'd2: regs_d.ofs[7:0]   = cpu_wdata;
                3'd3: regs_d.ofs[15:8]  = cpu_wdata;
                3'd4: regs_d.bank       = cpu_wdata;
                3'd5: regs_d.cnt[7:0]   = cpu_wdata;
                3'd6: regs_d.cnt[15:8]  = cpu_wdata;
                default: ;
            endcase
        end else if (adv) begin
            regs_d.ofs = ofs_next;
            regs_d.cnt = regs_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    always_comb begin
        case (cpu_addr)
            3'd0:    cpu_rdata = regs_q.ctrl;
            3'd1:    cpu_rdata = regs_q.bbase;
            3'd2:    cpu_rdata = regs_q.ofs[7:0];
            3'd3:    cpu_rdata = regs_q.ofs[15:8];
            3'd4:    cpu_rdata = regs_q.bank;
            3'd5:    cpu_rdata = regs_q.cnt[7:0];
            3'd6:    cpu_rdata = regs_q.cnt[15:8];
            default: cpu_rdata = '0;
        endcase
    end

    assign regs = regs_q;

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        adv |=> regs_q.cnt == $past(regs_q.cnt) - 1'b1); // R4
    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (rst)
        adv |=> $stable(regs_q.bank)); // R5
endmodule

// File: rtl/dma_pattern_chan.sv
module dma_pattern_chan
    import dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              a_req,
    output logic              a_we,
    output logic [ABUS_W-1:0] a_addr,
    output logic [DATA_W-1:0] a_wdata,
    input  logic [DATA_W-1:0] a_rdata,
    input  logic              a_ready,
    output logic              b_req,
    output logic              b_we,
    output logic [DATA_W-1:0] b_addr,
    output logic [DATA_W-1:0] b_wdata,
    input  logic [DATA_W-1:0] b_rdata,
    input  logic              b_ready
);
    eng_t             eng_d, eng_q;
    chan_regs_t       regs;
    logic             adv;
    logic [OFS_W-1:0] ofs_next;
    logic [PAT_W-1:0] off;
    logic             dir, fixed, down;
    logic             src_ready, dst_ready;
    logic [DATA_W-1:0] src_rdata;

    assign dir   = regs.ctrl[CTL_DIR];
    assign fixed = regs.ctrl[CTL_FIX];
    assign down  = regs.ctrl[CTL_DEC];
    assign busy  = (eng_q.st != ST_IDLE);
    assign done  = eng_q.done;

    dma_chan_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .cpu_we    (reg_we && !busy),
        .cpu_addr  (reg_addr),
        .cpu_wdata (reg_wdata),
        .cpu_rdata (reg_rdata),
        .adv       (adv),
        .ofs_next  (ofs_next),
        .regs      (regs)
    );

    dma_addr_step u_step (
        .ofs      (regs.ofs),
        .fixed    (fixed),
        .down     (down),
        .ofs_next (ofs_next)
    );

    dma_pattern_gen u_pat (
        .mode (regs.ctrl[MODE_W-1:0]),
        .idx  (eng_q.idx),
        .off  (off)
    );

    assign src_ready = dir ? b_ready : a_ready;
    assign dst_ready = dir ? a_ready : b_ready;
    assign src_rdata = dir ? b_rdata : a_rdata;

    always_comb begin
        eng_d      = eng_q;
        eng_d.done = 1'b0;
        adv        = 1'b0;
        case (eng_q.st)
            ST_IDLE: begin
                if (start) begin
                    eng_d.st  = ST_RD;
                    eng_d.idx = '0;
                end
            end
            ST_RD: begin
                if (src_ready) begin
                    eng_d.data = src_rdata;
                    eng_d.st   = ST_WR;
                end
            end
            ST_WR: begin
                if (dst_ready) begin
                    adv       = 1'b1;
                    eng_d.idx = eng_q.idx + 1'b1;
                    if (regs.cnt == CNT_W'(1)) begin
                        eng_d.st   = ST_IDLE;
                        eng_d.done = 1'b1;
                    end else begin
                        eng_d.st = ST_RD;
                    end
                end
            end
            default: eng_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            eng_q <= '0;
        else
            eng_q <= eng_d;
    end

    assign a_req   = (eng_q.st == ST_RD && !dir) || (eng_q.st == ST_WR && dir);
    assign a_we    = (eng_q.st == ST_WR) && dir;
    assign b_req   = (eng_q.st == ST_RD && dir) || (eng_q.st == ST_WR && !dir);
    assign b_we    = (eng_q.st == ST_WR) && !dir;
    assign a_addr  = {regs.bank, regs.ofs};
    assign b_addr  = regs.bbase + {{(DATA_W-PAT_W){1'b0}}, off};
    assign a_wdata = eng_q.data;
    assign b_wdata = eng_q.data;

    AST_ONE_BUS: assert property (@(posedge clk) disable iff (rst)
        !(a_req && b_req)); // R9
    AST_A_HOLD: assert property (@(posedge clk) disable iff (rst)
        (a_req && !a_ready) |=> (a_req && $stable(a_addr) && $stable(a_we))); // R9
    AST_B_HOLD: assert property (@(posedge clk) disable iff (rst)
        (b_req && !b_ready) |=> (b_req && $stable(b_addr) && $stable(b_we))); // R9
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R10
    AST_FIXED_HOLD: assert property (@(posedge clk) disable iff (rst)
        (adv && fixed) |=> $stable(a_addr)); // R5
endmodule

// File: tb/sim_dma_pattern_chan.sv
module sim_dma_pattern_chan;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        start = 1'b0;
    logic        busy, done;
    logic        a_req, a_we, a_ready = 1'b0;
    logic [23:0] a_addr;
    logic [7:0]  a_wdata, a_rdata;
    logic        b_req, b_we, b_ready = 1'b0;
    logic [7:0]  b_addr, b_wdata, b_rdata;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit all_ready = 1'b0;
    bit active = 1'b0;

    logic [2:0]  e_mode;
    logic [7:0]  e_bbase, e_bank;
    logic [15:0] e_ofs;
    bit          e_dir, e_fix, e_dec;
    int          e_total, widx, ridx, done_cnt, last_wr;

    dma_pattern_chan u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] fa(input logic [23:0] ad);
        return ad[7:0] ^ ad[15:8] ^ ad[23:16] ^ 8'h3C;
    endfunction
    function automatic logic [7:0] fb(input logic [7:0] ad);
        return ~ad ^ 8'h96;
    endfunction
    assign a_rdata = fa(a_addr);
    assign b_rdata = fb(b_addr);

    function automatic int pat(input logic [2:0] m, input int i);
        case (m)
            3'd1, 3'd5: return i % 2;
            3'd3, 3'd7: return (i / 2) % 2;
            3'd4:       return i % 4;
            default:    return 0;
        endcase
    endfunction
    function automatic logic [15:0] ofs_at(input int i);
        if (e_fix) return e_ofs;
        return e_dec ? e_ofs - 16'(i) : e_ofs + 16'(i);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            if (errors < 30)
                $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        #1;
        a_ready <= all_ready ? 1'b1 : (($urandom % 4) != 0);
        b_ready <= all_ready ? 1'b1 : (($urandom % 4) != 0);
    end

    // monitor between edges: values here are those seen at the next posedge
    always @(negedge clk) begin
        logic [7:0] eb;
        logic [23:0] ea;
        cyc++;
        if (cyc > WATCHDOG) begin
            chk(0, "WDOG", "watchdog expired", cyc, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
        if (active) begin
            eb = e_bbase + 8'(pat(e_mode, widx));
            ea = {e_bank, ofs_at(widx)};
            if (!e_dir && b_req && b_we && b_ready) begin
                chk(b_addr == eb, "R1", "B write addr", b_addr, eb);
                chk(b_wdata == fa(ea), "R7", "B write data", b_wdata, fa(ea));
                widx++; last_wr = cyc;
            end
            if (e_dir && a_req && a_we && a_ready) begin
                chk(a_addr == ea, "R5", "A write addr", a_addr, ea);
                chk(a_wdata == fb(eb), "R7", "A write data", a_wdata, fb(eb));
                widx++; last_wr = cyc;
            end
            if (!e_dir && a_req && a_we) chk(0, "R7", "write on source A", 1, 0);
            if (e_dir && b_req && b_we) chk(0, "R7", "write on source B", 1, 0);
            if (!e_dir && a_req && !a_we && a_ready) begin
                chk(a_addr == ea, "R5", "A read addr", a_addr, ea);
                ridx++;
            end
            if (e_dir && b_req && !b_we && b_ready) begin
                chk(b_addr == eb, "R6", "B read addr", b_addr, eb);
                ridx++;
            end
            if (done) begin
                chk(!busy, "R10", "busy with done", busy, 0);
                chk(cyc == last_wr + 1, "R10", "done timing", cyc - last_wr, 1);
                done_cnt++;
            end
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask
    task automatic wreg(input logic [2:0] ad, input logic [7:0] d);
        reg_addr = ad; reg_wdata = d; reg_we = 1'b1;
        step();
        reg_we = 1'b0;
    endtask
    task automatic rreg(input logic [2:0] ad, output logic [7:0] d);
        reg_addr = ad; #1; d = reg_rdata;
    endtask

    task automatic run(input logic [7:0] ctrl, input logic [7:0] bb,
                       input logic [23:0] src, input logic [15:0] cnt,
                       input bit fast, input bit poke);
        logic [7:0] v;
        logic [15:0] fin;
        int guard;
        wreg(0, ctrl); wreg(1, bb); wreg(2, src[7:0]); wreg(3, src[15:8]);
        wreg(4, src[23:16]); wreg(5, cnt[7:0]); wreg(6, cnt[15:8]);
        e_mode = ctrl[2:0]; e_fix = ctrl[3]; e_dec = ctrl[4]; e_dir = ctrl[7];
        e_bbase = bb; e_bank = src[23:16]; e_ofs = src[15:0];
        e_total = (cnt == 0) ? 65536 : int'(cnt);
        widx = 0; ridx = 0; done_cnt = 0; last_wr = 0;
        all_ready = fast; active = 1'b1;
        start = 1'b1; step(); start = 1'b0;
        if (poke) begin
            step(); step();
            wreg(0, ~ctrl);
            start = 1'b1; step(); start = 1'b0;
        end
        guard = 0;
        while (done_cnt == 0 && guard < 150000) begin step(); guard++; end
        step(); step();
        active = 1'b0; all_ready = 1'b0;
        chk(widx == e_total, "R2", "bytes written", widx, e_total);
        chk(ridx == e_total, "R9", "bytes read", ridx, e_total);
        chk(done_cnt == 1, "R10", "done pulses", done_cnt, 1);
        rreg(5, v); chk(v == 0, "R4", "count low after", v, 0);
        rreg(6, v); chk(v == 0, "R4", "count high after", v, 0);
        fin = e_fix ? e_ofs : (e_dec ? e_ofs - 16'(e_total) : e_ofs + 16'(e_total));
        rreg(2, v); chk(v == fin[7:0], "R5", "offset low after", v, fin[7:0]);
        rreg(3, v); chk(v == fin[15:8], "R5", "offset high after", v, fin[15:8]);
        rreg(4, v); chk(v == e_bank, "R5", "bank after", v, e_bank);
        if (poke) begin
            rreg(0, v); chk(v == ctrl, "R11", "ctrl write while busy", v, ctrl);
        end
    endtask

    initial begin
        logic [7:0] v;
        void'($urandom(32'd20240611));
        repeat (3) step();
        for (int i = 0; i < 7; i++) begin
            rreg(3'(i), v); chk(v == 8'hFF, "R8", "power-up value", v, 8'hFF);
        end
        rst = 1'b0;
        step();
        chk(!busy && !done && !a_req && !b_req, "R10", "idle after reset",
            {busy, done, a_req, b_req}, 0);
        // directed corners
        run(8'h04, 8'h10, 24'h12_3400, 16'd5, 0, 0);   // R2 cut pattern
        run(8'h00, 8'h22, 24'h01_0000, 16'd1, 0, 0);   // R2 single access
        run(8'h05, 8'hFF, 24'h02_0010, 16'd9, 0, 0);   // R6 base wrap
        run(8'h03, 8'h40, 24'h7F_FFFE, 16'd7, 0, 0);   // R5 increment wrap
        run(8'h11, 8'h50, 24'h33_0001, 16'd6, 0, 0);   // R5 decrement wrap
        run(8'h8C, 8'hFE, 24'h44_1234, 16'd8, 0, 0);   // R7 reverse, fixed
        run(8'h06, 8'h60, 24'h05_0100, 16'd10, 0, 1);  // R11 busy ignores
        // random mix, R1 all modes
        for (int i = 0; i < 14; i++)
            run({$urandom % 2 == 1, 3'b000, 4'($urandom)}, 8'($urandom),
                24'($urandom), 16'(1 + $urandom % 40), 0, 0);
        // R8 reset leaves registers alone
        wreg(0, 8'hA5); wreg(1, 8'h5A); wreg(5, 8'h33);
        rst = 1'b1; step(); step(); rst = 1'b0; step();
        rreg(0, v); chk(v == 8'hA5, "R8", "ctrl across reset", v, 8'hA5);
        rreg(1, v); chk(v == 8'h5A, "R8", "base across reset", v, 8'h5A);
        rreg(5, v); chk(v == 8'h33, "R8", "count across reset", v, 8'h33);
        // R3 zero count moves 65536 bytes
        run(8'h04, 8'h80, 24'h09_C000, 16'h0000, 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule